// File: doc/BRIEF.md
# Framed Serial Sample Transmitter

This block sends one word per frame on a serial data line. It makes its own serial clock at half the master clock rate. An active-low frame strobe frames each word. A conversion stage hands it a sample with a valid/ready handshake. The word is built from the sample, then five status bits taken from plain flag inputs, then three zero bits.

Software can ask to read a register instead. It pulses a read request with an address. The block then drives that address out to a register file and waits. If the request has been pending for long enough before the next frame starts, that frame carries the 32-bit register value in place of the sample. This happens exactly once, and later frames carry samples again.

Back-pressure rules: `smp_ready` is high only when no frame is in flight or waiting to start. A beat on `smp_valid` while `smp_ready` is low is dropped and has no effect. The source does not need to hold `smp_valid`; the block accepts a sample on the one cycle where both are high.

Top module: `serial_frame_tx`

## Requirements
- R1: `sco` is low during reset and after reset toggles on every master clock edge, so it runs at half the master clock frequency.
- R2: `fso_n` stays low for exactly 32 `sco` periods per frame and returns high on the `sco` rising edge after the last bit.
- R3: `sdo` and `fso_n` change only on a rising `sco` edge, so they are stable at the falling edge. The most significant bit of the word is sent first.
- R4: Between frames, `sdo` is low and `fso_n` is high.
- R5: In a sample frame, word bits 31..8 are the sample and bits 2..0 are zero.
- R6: Status bits, taken at the handshake, are placed as follows: bit 7 is the settled bit, bit 6 is overrange, bit 5 is low-power mode, and bits 4..3 are `dec_code[1:0]`.
- R7: Bit 7 is 1 only when `flt_settled` is 1 and `ovr_alert` is 0.
- R8: Word bit 4 equals `dec_code[1]`, where 1 means a ratio of 128 and 0 means a ratio of 256. Word bit 3 equals `dec_code[0]`.
- R9: A read request that has been pending for at least 8 `sco` periods when a frame starts makes that frame carry `reg_rdata` for `reg_addr`. This consumes the request, and the following frames carry samples.
- R10: A read request made too close to a frame start leaves that frame as a sample frame. The register is sent in the next frame.
- R11: `smp_ready` is high after reset and low while a frame is pending or in flight. A `smp_valid` beat while it is low changes neither the current frame nor starts another.
- R12: A frame starts, with `fso_n` falling together with a `sco` rise, at the first `sco` rising edge after the handshake: one or two master clocks later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | Sample valid |
| smp_ready | output | 1 | Block can accept a sample |
| smp_data | input | SMP_W (24) | Conversion sample |
| flt_settled | input | 1 | Filter has settled |
| ovr_alert | input | 1 | Overrange alert active |
| lowpwr_mode | input | 1 | Low-power mode active |
| dec_code | input | 2 | Decimation code |
| rd_req | input | 1 | Register read request pulse |
| rd_addr | input | ADDR_W (4) | Register to read |
| reg_addr | output | ADDR_W (4) | Address presented to the register file |
| reg_rdata | input | WORD_W (32) | Register value for `reg_addr` |
| sco | output | 1 | Serial clock, half the master clock rate |
| fso_n | output | 1 | Active-low frame strobe |
| sdo | output | 1 | Serial data |

## Verification
The bench builds the block with its default values: a 24-bit sample, a 4-bit register address and a lead of 8 serial clock periods. These values give the 32-bit frame the fixed 24/5/3 split that the field checks rely on. Because 8 periods is short next to a 64-clock frame, one late request becomes ready during a single frame. That makes the case where a request misses one frame and lands in the next easy to reach. A lead of 8 also leaves room for requests made far ahead or one clock ahead, which fall clearly on each side of the deadline.

// File: rtl/sftx_pkg.sv
`timescale 1ns/1ps
package sftx_pkg;
  localparam int STAT_W = 5;
  localparam int PAD_W  = 3;

  typedef struct packed {
    logic       settled;
    logic       ovr;
    logic       lpwr;
    logic [1:0] dec;
  } sftx_stat_t;

  // settled bit is masked while the overrange alert is raised
  function automatic logic [STAT_W-1:0] pack_status(input sftx_stat_t s);
    return {s.settled & ~s.ovr, s.ovr, s.lpwr, s.dec};
  endfunction
endpackage

// File: rtl/sftx_sclk_gen.sv
`timescale 1ns/1ps
module sftx_sclk_gen (
  input  logic clk,
  input  logic rst_n,
  output logic sco,
  output logic rise_tick
);
  logic sco_q;

  always_ff @(posedge clk) begin
    if (!rst_n) sco_q <= 1'b0;
    else        sco_q <= ~sco_q;
  end

  assign sco       = sco_q;
  assign rise_tick = ~sco_q;   // this edge drives sco high
endmodule

// File: rtl/sftx_rd_sel.sv
`timescale 1ns/1ps
module sftx_rd_sel #(
  parameter int ADDR_W   = 4,
  parameter int LEAD_SCO = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_req,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              rise_tick,
  input  logic              frame_start,
  output logic              use_reg,
  output logic [ADDR_W-1:0] reg_addr
);
  localparam int AGE_W = $clog2(LEAD_SCO + 1);

  logic              pending;
  logic [AGE_W-1:0]  age;
  logic [ADDR_W-1:0] addr_q;

  assign use_reg  = pending && (age >= AGE_W'(LEAD_SCO));
  assign reg_addr = addr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pending <= 1'b0;
      age     <= '0;
      addr_q  <= '0;
    end else if (rd_req) begin
      pending <= 1'b1;
      age     <= '0;
      addr_q  <= rd_addr;
    end else if (frame_start && use_reg) begin
      pending <= 1'b0;
      age     <= '0;
    end else if (pending && rise_tick && (age < AGE_W'(LEAD_SCO))) begin
      age <= age + 1'b1;
    end
  end

  assert_consume_once_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && use_reg && !rd_req) |=> !pending);
endmodule

// File: rtl/sftx_shifter.sv
`timescale 1ns/1ps
module sftx_shifter #(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sco,
  input  logic              rise_tick,
  input  logic              load_req,
  input  logic [WORD_W-1:0] word_in,
  output logic              frame_start,
  output logic              busy,
  output logic              sdo,
  output logic              fso_n
);
  localparam int CNT_W = $clog2(WORD_W);

  logic              start_pend;
  logic              active;
  logic [CNT_W-1:0]  bitcnt;
  logic [WORD_W-1:0] shreg;

  assign frame_start = rise_tick && start_pend && !active;
  assign busy        = start_pend || active;
  assign sdo         = active && shreg[WORD_W-1];
  assign fso_n       = !active;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      start_pend <= 1'b0;
      active     <= 1'b0;
      bitcnt     <= '0;
      shreg      <= '0;
    end else begin
      if (load_req) start_pend <= 1'b1;
      if (rise_tick) begin
        if (active) begin
          if (bitcnt == CNT_W'(WORD_W-1)) begin
            active <= 1'b0;
          end else begin
            bitcnt <= bitcnt + 1'b1;
            shreg  <= {shreg[WORD_W-2:0], 1'b0};
          end
        end else if (start_pend) begin
          active     <= 1'b1;
          start_pend <= 1'b0;
          bitcnt     <= '0;
          shreg      <= word_in;
        end
      end
    end
  end

  assert_sdo_on_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (sdo != $past(sdo)) |-> (sco && !$past(sco)));
  assert_fso_on_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (fso_n != $past(fso_n)) |-> (sco && !$past(sco)));
  assert_frame_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fso_n) |-> ($past(bitcnt) == CNT_W'(WORD_W-1)));
endmodule

// File: rtl/serial_frame_tx.sv
`timescale 1ns/1ps
module serial_frame_tx
  import sftx_pkg::*;
#(
  parameter  int SMP_W    = 24,
  parameter  int ADDR_W   = 4,
  parameter  int LEAD_SCO = 8,
  localparam int WORD_W   = SMP_W + STAT_W + PAD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_valid,
  output logic              smp_ready,
  input  logic [SMP_W-1:0]  smp_data,
  input  logic              flt_settled,
  input  logic              ovr_alert,
  input  logic              lowpwr_mode,
  input  logic [1:0]        dec_code,
  input  logic              rd_req,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [ADDR_W-1:0] reg_addr,
  input  logic [WORD_W-1:0] reg_rdata,
  output logic              sco,
  output logic              fso_n,
  output logic              sdo
);
  logic              rise_tick, frame_start, busy, use_reg, accept;
  logic [WORD_W-1:0] hold_word, word_in;
  sftx_stat_t        stat;

  assign stat      = '{settled: flt_settled, ovr: ovr_alert, lpwr: lowpwr_mode, dec: dec_code};
  assign smp_ready = !busy;
  assign accept    = smp_valid && smp_ready;
  assign word_in   = use_reg ? reg_rdata : hold_word;

  always_ff @(posedge clk) begin
    if (!rst_n)      hold_word <= '0;
    else if (accept) hold_word <= {smp_data, pack_status(stat), PAD_W'(0)};
  end

  sftx_sclk_gen u_clk (
    .clk(clk), .rst_n(rst_n), .sco(sco), .rise_tick(rise_tick)
  );

  sftx_rd_sel #(.ADDR_W(ADDR_W), .LEAD_SCO(LEAD_SCO)) u_sel (
    .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .rd_addr(rd_addr),
    .rise_tick(rise_tick), .frame_start(frame_start),
    .use_reg(use_reg), .reg_addr(reg_addr)
  );

  sftx_shifter #(.WORD_W(WORD_W)) u_shf (
    .clk(clk), .rst_n(rst_n), .sco(sco), .rise_tick(rise_tick),
    .load_req(accept), .word_in(word_in), .frame_start(frame_start),
    .busy(busy), .sdo(sdo), .fso_n(fso_n)
  );

  assert_no_ready_in_frame_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !fso_n |-> !smp_ready);
endmodule

// File: tb/serial_frame_tx_bench.sv
`timescale 1ns/1ps
module serial_frame_tx_bench;
  localparam int SMP_W = 24, ADDR_W = 4, W = 32;

  logic clk = 1'b0, rst_n = 1'b0;
  logic smp_valid = 1'b0, smp_ready;
  logic [SMP_W-1:0] smp_data = '0;
  logic flt_settled = 1'b0, ovr_alert = 1'b0, lowpwr_mode = 1'b0;
  logic [1:0] dec_code = 2'b00;
  logic rd_req = 1'b0;
  logic [ADDR_W-1:0] rd_addr = '0, reg_addr;
  logic [W-1:0] reg_rdata;
  logic sco, fso_n, sdo;

  int n_chk = 0, n_err = 0;
  bit done = 1'b0;
  time accept_t;

  always #2 clk = ~clk;

  function automatic logic [W-1:0] reg_model(input logic [ADDR_W-1:0] a);
    return {8'h5A, {2{a}}, 16'hC3E1 ^ {4{a}}};
  endfunction
  assign reg_rdata = reg_model(reg_addr);

  function automatic logic [W-1:0] exp_word(input logic [SMP_W-1:0] d,
      input logic st, input logic ov, input logic lp, input logic [1:0] dc);
    return {d, st & ~ov, ov, lp, dc, 3'b000};
  endfunction

  serial_frame_tx u_serial_frame_tx (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_ready(smp_ready),
    .smp_data(smp_data), .flt_settled(flt_settled), .ovr_alert(ovr_alert),
    .lowpwr_mode(lowpwr_mode), .dec_code(dec_code), .rd_req(rd_req),
    .rd_addr(rd_addr), .reg_addr(reg_addr), .reg_rdata(reg_rdata),
    .sco(sco), .fso_n(fso_n), .sdo(sdo)
  );

  task automatic chk(input bit ok, input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send(input logic [SMP_W-1:0] d, input logic st, input logic ov,
                      input logic lp, input logic [1:0] dc);
    @(negedge clk);
    while (!smp_ready) @(negedge clk);
    smp_data = d; flt_settled = st; ovr_alert = ov; lowpwr_mode = lp; dec_code = dc;
    smp_valid = 1'b1;
    @(posedge clk);
    accept_t = $time;
    #1 smp_valid = 1'b0;
  endtask

  task automatic capture(output logic [W-1:0] w);
    bit fso_ok = 1'b1;
    time dt;
    w = '0;
    @(negedge fso_n);
    dt = $time - accept_t;
    #1;
    chk(sco == 1'b1 && (dt == 4 || dt == 8), "R12 start timing", W'(dt), W'(8));
    for (int i = 0; i < W; i++) begin
      @(negedge sco);
      #1;
      if (fso_n) fso_ok = 1'b0;
      w = {w[W-2:0], sdo};
    end
    chk(fso_ok, "R2 strobe low for all bits", W'(fso_ok), W'(1));
    @(posedge sco);
    #1;
    chk(fso_n == 1'b1 && sdo == 1'b0, "R2 R4 strobe ends after 32 periods",
        W'({fso_n, sdo}), W'(2'b10));
  endtask

  task automatic rd_pulse(input logic [ADDR_W-1:0] a);
    @(negedge clk);
    rd_addr = a; rd_req = 1'b1;
    @(negedge clk);
    rd_req = 1'b0;
  endtask

  initial begin
    #800000;
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] w, e;
    logic [SMP_W-1:0] d;
    logic st, ov, lp;
    logic [1:0] dc;
    int bad;
    void'($urandom(32'd1234));

    repeat (3) @(negedge clk);
    chk(sco == 1'b0, "R1 sco low in reset", W'(sco), W'(0));
    chk(fso_n == 1'b1 && sdo == 1'b0, "R4 idle in reset", W'({fso_n, sdo}), W'(2'b10));
    rst_n = 1'b1;
    @(negedge clk);
    chk(smp_ready == 1'b1, "R11 ready after reset", W'(smp_ready), W'(1));
    bad = 0;
    for (int k = 0; k < 8; k++) begin
      logic s;
      s = sco;
      @(negedge clk);
      if (sco == s) bad++;
    end
    chk(bad == 0, "R1 sco toggles each master clock", W'(bad), W'(0));
    chk(fso_n == 1'b1 && sdo == 1'b0, "R4 idle before any frame", W'({fso_n, sdo}), W'(2'b10));

    // directed: overrange masks settled, decimation 128
    send(24'hA5C3F0, 1'b1, 1'b1, 1'b0, 2'b10);
    capture(w);
    e = exp_word(24'hA5C3F0, 1'b1, 1'b1, 1'b0, 2'b10);
    chk(w == e, "R5 R6 word layout msb first", w, e);
    chk(w[7] == 1'b0, "R7 settled masked by overrange", W'(w[7]), W'(0));
    chk(w[4:3] == 2'b10, "R8 decimation bits ratio 128", W'(w[4:3]), W'(2'b10));

    send(24'h000001, 1'b1, 1'b0, 1'b1, 2'b01);
    capture(w);
    e = exp_word(24'h000001, 1'b1, 1'b0, 1'b1, 2'b01);
    chk(w == e, "R6 R7 settled and low-power set", w, e);
    chk(w[4] == 1'b0 && w[2:0] == 3'b000, "R8 R5 ratio 256 and zero pad", W'(w[4:0]), W'(5'b01000));

    // ignored strobe during a frame
    send(24'h123456, 1'b0, 1'b0, 1'b0, 2'b11);
    e = exp_word(24'h123456, 1'b0, 1'b0, 1'b0, 2'b11);
    fork
      capture(w);
      begin
        repeat (20) @(negedge clk);
        chk(smp_ready == 1'b0, "R11 not ready in frame", W'(smp_ready), W'(0));
        smp_data = 24'hFFFFFF; flt_settled = 1'b1; smp_valid = 1'b1;
        repeat (3) @(negedge clk);
        smp_valid = 1'b0;
      end
    join
    chk(w == e, "R11 dropped beat leaves frame unchanged", w, e);
    bad = 0;
    repeat (100) begin
      @(negedge clk);
      if (!fso_n || sdo) bad++;
    end
    chk(bad == 0, "R11 R4 dropped beat starts no frame", W'(bad), W'(0));

    // early request: register frame once, then samples
    rd_pulse(4'h5);
    repeat (60) @(negedge clk);
    send(24'h0F0F0F, 1'b1, 1'b0, 1'b0, 2'b00);
    capture(w);
    chk(w == reg_model(4'h5), "R9 register replaces sample", w, reg_model(4'h5));
    send(24'h0F0F0F, 1'b1, 1'b0, 1'b0, 2'b00);
    capture(w);
    e = exp_word(24'h0F0F0F, 1'b1, 1'b0, 1'b0, 2'b00);
    chk(w == e, "R9 request consumed, sample returns", w, e);

    // late request: misses one frame, lands in the next
    rd_pulse(4'h9);
    send(24'h777777, 1'b0, 1'b1, 1'b1, 2'b01);
    capture(w);
    e = exp_word(24'h777777, 1'b0, 1'b1, 1'b1, 2'b01);
    chk(w == e, "R10 late request keeps sample frame", w, e);
    send(24'h888888, 1'b0, 1'b0, 1'b0, 2'b00);
    capture(w);
    chk(w == reg_model(4'h9), "R10 register in following frame", w, reg_model(4'h9));
    send(24'h999999, 1'b1, 1'b0, 1'b0, 2'b10);
    capture(w);
    e = exp_word(24'h999999, 1'b1, 1'b0, 1'b0, 2'b10);
    chk(w == e, "R9 later frames are samples", w, e);

    // random frames
    for (int n = 0; n < 24; n++) begin
      d = SMP_W'($urandom);
      {st, ov, lp, dc} = 5'($urandom);
      repeat ($urandom_range(0, 10)) @(negedge clk);
      send(d, st, ov, lp, dc);
      capture(w);
      e = exp_word(d, st, ov, lp, dc);
      chk(w == e, "R5 R6 R7 R8 random frame", w, e);
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule